// File: doc/BRIEF.md
# Clock-Compensation Elastic Buffer

This block sits between a receiver running on a recovered clock and logic running on a local clock of nominally equal frequency. Words enter on the write clock and leave on the read clock. The two clocks may differ by a few hundred ppm. To stop the queue from overflowing or running dry, the buffer adjusts only designated skip words. When the buffer runs too full, it discards an incoming skip word. When it runs too shallow, it repeats a skip word on the output. Ordinary data words are never dropped or duplicated while the occupancy stays inside the band.

The write and read pointers cross between the clock domains as Gray code through two-flop synchronizers. Each side converts the pointer it receives back to binary and works out an occupancy estimate of its own. After reset the read side holds off until it sees half the depth stored, which starts the queue in the middle of its range.

Write side (`in_*`): the writer presents a word with `in_valid`. A word is accepted on every clock edge where `in_valid` and `in_ready` are both high. `in_ready` rises one write clock after reset is released and then stays high, because a recovered stream cannot be stalled. Overflow is therefore handled by discarding the word, not by back-pressure. Read side (`out_*`): a word is taken on every read clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented word stays unchanged and the read pointer does not move. Holding `out_ready` low therefore acts like a slower reader.

Top module: `clk_comp_buf`

## Requirements
- R1: Non-skip words that are accepted while the occupancy stays between the two limits appear at the output once each, in the order they were written.
- R2: If a word flagged as skip is accepted while the write-side occupancy is at or above HI_MARK (default 12), the word is not stored, and `del_pulse` is high for one write clock.
- R3: If an output word is due, the head of the queue is a skip word and the read-side occupancy is at or below LO_MARK (default 4), the buffer presents SKIP_CODE with `out_skip`=1 and does not advance the read pointer. `ins_pulse` is high for that read clock.
- R4: A non-skip word is never discarded or repeated because of the HI_MARK or LO_MARK limits. The adjustment waits until a skip word is available.
- R5: An accepted word that finds the write-side occupancy at the full depth (16) is discarded, and `full_pulse` is high for one write clock. `full_err` then stays high until the write reset.
- R6: If an output word is due and the read side sees no stored word, the buffer presents SKIP_CODE with `out_skip`=1, and `empty_pulse` is high for one read clock. `empty_err` then stays high until the read reset.
- R7: After reset, `out_valid` and every status output are 0. `out_valid` stays 0 until the read side sees at least DEPTH/2 (8) stored words.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_skip` hold their values. `in_ready`=1 from the first write clock after reset.
- R9: With a continuous input stream that has a skip word in every fourth slot and a write clock 300 ppm fast, then 300 ppm slow, neither `full_err` nor `empty_err` is set. The fast phase produces deletions and the slow phase produces insertions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered (write) clock |
| wrst_n | input | 1 | Active-low reset, write domain |
| rclk | input | 1 | Local (read) clock |
| rrst_n | input | 1 | Active-low reset, read domain |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Write side accepting (high after reset) |
| in_data | input | DW | Input word |
| in_skip | input | 1 | Input word is a skip character |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | DW | Output word |
| out_skip | output | 1 | Output word is a skip character |
| del_pulse | output | 1 | Skip word deleted (write clock pulse) |
| full_pulse | output | 1 | Word discarded on full (write clock pulse) |
| full_err | output | 1 | Sticky full indication |
| ins_pulse | output | 1 | Skip word inserted (read clock pulse) |
| empty_pulse | output | 1 | Empty encountered (read clock pulse) |
| empty_err | output | 1 | Sticky empty indication |

## Verification
The bound checker tests several properties on every cycle. A deletion must follow an accepted skip word, and a deletion and a full discard never coincide. Inserted and empty-fill words must carry SKIP_CODE with the skip flag set, and the two sticky error bits must never fall. A stalled output must also hold still. Other properties need whole scenarios, and only the scoreboard scenarios can show them. These are in-order, exactly-once delivery of data words across two ppm offsets, the fact that deletions and insertions actually occur, priming to half depth, and the exact set of words that survives a forced overflow followed by a drain into empty.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
  // what the read side does with the output register on a given cycle
  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_PASS   = 2'd1,
    RD_INSERT = 2'd2,
    RD_EMPTY  = 2'd3
  } rd_act_e;
endpackage

// File: rtl/ccb_sync.sv
module ccb_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ccb_gray2bin.sv
module ccb_gray2bin #(
  parameter int W = 5
) (
  input  logic [W-1:0] g,
  output logic [W-1:0] b
);
  assign b[W-1] = g[W-1];
  for (genvar i = 0; i < W - 1; i++) begin : g_bit
    assign b[i] = ^g[W-1:i];
  end
endmodule

// File: rtl/ccb_wr_ctrl.sv
module ccb_wr_ctrl #(
  parameter int AW      = 4,
  parameter int HI_MARK = 12
) (
  input  logic        wclk,
  input  logic        wrst_n,
  input  logic        in_valid,
  input  logic        in_skip,
  input  logic [AW:0] rgray_s,
  output logic        in_ready,
  output logic        we,
  output logic [AW:0] wptr,
  output logic [AW:0] wgray,
  output logic        del_pulse,
  output logic        full_pulse,
  output logic        full_err
);
  localparam int          DEPTH = 1 << AW;
  localparam logic [AW:0] HI_L  = HI_MARK[AW:0];
  localparam logic [AW:0] FULL_L = DEPTH[AW:0];

  logic [AW:0] rbin;
  logic [AW:0] occ;
  logic [AW:0] wptr_nxt;
  logic        accept;
  logic        drop_skip;
  logic        drop_full;

  ccb_gray2bin #(.W(AW + 1)) u_g2b (.g(rgray_s), .b(rbin));

  assign occ       = wptr - rbin;
  assign accept    = in_valid & in_ready;
  assign drop_skip = accept & in_skip & (occ >= HI_L);
  assign drop_full = accept & ~drop_skip & (occ >= FULL_L);
  assign we        = accept & ~drop_skip & ~drop_full;
  assign wptr_nxt  = wptr + {{AW{1'b0}}, we};

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      in_ready   <= 1'b0;
      wptr       <= '0;
      wgray      <= '0;
      del_pulse  <= 1'b0;
      full_pulse <= 1'b0;
      full_err   <= 1'b0;
    end else begin
      in_ready   <= 1'b1;
      wptr       <= wptr_nxt;
      wgray      <= wptr_nxt ^ (wptr_nxt >> 1);
      del_pulse  <= drop_skip;
      full_pulse <= drop_full;
      full_err   <= full_err | drop_full;
    end
  end
endmodule

// File: rtl/ccb_rd_ctrl.sv
module ccb_rd_ctrl
  import ccb_pkg::*;
#(
  parameter int          AW        = 4,
  parameter int          DW        = 16,
  parameter int          LO_MARK   = 4,
  parameter logic [DW-1:0] SKIP_CODE = '0
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] head_data,
  input  logic          head_skip,
  input  logic          out_ready,
  output logic [AW:0]   rptr,
  output logic [AW:0]   rgray,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_skip,
  output logic          ins_pulse,
  output logic          empty_pulse,
  output logic          empty_err
);
  localparam int          DEPTH  = 1 << AW;
  localparam logic [AW:0] HALF_L = (DEPTH / 2);
  localparam logic [AW:0] LO_L   = LO_MARK[AW:0];

  logic [AW:0] wbin;
  logic [AW:0] occ;
  logic [AW:0] rptr_nxt;
  logic        primed;
  logic        take;
  rd_act_e     act;

  ccb_gray2bin #(.W(AW + 1)) u_g2b (.g(wgray_s), .b(wbin));

  assign occ  = wbin - rptr;
  assign take = primed & (out_ready | ~out_valid);

  always_comb begin
    if (!take)                            act = RD_IDLE;
    else if (occ == '0)                   act = RD_EMPTY;
    else if (head_skip && (occ <= LO_L))  act = RD_INSERT;
    else                                  act = RD_PASS;
  end

  assign rptr_nxt = rptr + {{AW{1'b0}}, (act == RD_PASS)};

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      primed      <= 1'b0;
      rptr        <= '0;
      rgray       <= '0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_skip    <= 1'b0;
      ins_pulse   <= 1'b0;
      empty_pulse <= 1'b0;
      empty_err   <= 1'b0;
    end else begin
      primed      <= primed | (occ >= HALF_L);
      rptr        <= rptr_nxt;
      rgray       <= rptr_nxt ^ (rptr_nxt >> 1);
      out_valid   <= out_valid | take;
      ins_pulse   <= (act == RD_INSERT);
      empty_pulse <= (act == RD_EMPTY);
      empty_err   <= empty_err | (act == RD_EMPTY);
      case (act)
        RD_PASS: begin
          out_data <= head_data;
          out_skip <= head_skip;
        end
        RD_INSERT, RD_EMPTY: begin
          out_data <= SKIP_CODE;
          out_skip <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ccb_store.sv
module ccb_store #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          wskip,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rskip
);
  localparam int DEPTH = 1 << AW;

  logic [DW:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= {wskip, wdata};
  end

  assign {rskip, rdata} = mem[raddr];
endmodule

// File: rtl/clk_comp_buf.sv
module clk_comp_buf #(
  parameter int            DW        = 16,
  parameter int            AW        = 4,
  parameter int            HI_MARK   = 12,
  parameter int            LO_MARK   = 4,
  parameter logic [DW-1:0] SKIP_CODE = 16'h01BC
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_skip,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_skip,
  output logic          del_pulse,
  output logic          full_pulse,
  output logic          full_err,
  output logic          ins_pulse,
  output logic          empty_pulse,
  output logic          empty_err
);
  logic [AW:0]   wptr, wgray, wgray_s;
  logic [AW:0]   rptr, rgray, rgray_s;
  logic          we;
  logic [DW-1:0] head_data;
  logic          head_skip;

  ccb_wr_ctrl #(.AW(AW), .HI_MARK(HI_MARK)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .in_valid(in_valid), .in_skip(in_skip),
    .rgray_s(rgray_s), .in_ready(in_ready), .we(we), .wptr(wptr),
    .wgray(wgray), .del_pulse(del_pulse), .full_pulse(full_pulse),
    .full_err(full_err)
  );

  ccb_sync #(.W(AW + 1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  ccb_sync #(.W(AW + 1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  ccb_store #(.AW(AW), .DW(DW)) u_mem (
    .wclk(wclk), .we(we), .waddr(wptr[AW-1:0]), .wdata(in_data),
    .wskip(in_skip), .raddr(rptr[AW-1:0]), .rdata(head_data),
    .rskip(head_skip)
  );

  ccb_rd_ctrl #(.AW(AW), .DW(DW), .LO_MARK(LO_MARK), .SKIP_CODE(SKIP_CODE)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .wgray_s(wgray_s), .head_data(head_data),
    .head_skip(head_skip), .out_ready(out_ready), .rptr(rptr), .rgray(rgray),
    .out_valid(out_valid), .out_data(out_data), .out_skip(out_skip),
    .ins_pulse(ins_pulse), .empty_pulse(empty_pulse), .empty_err(empty_err)
  );
endmodule

// File: rtl/ccb_chk.sv
module ccb_chk #(
  parameter int            DW        = 16,
  parameter logic [DW-1:0] SKIP_CODE = '0
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          in_valid,
  input logic          in_skip,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_skip,
  input logic          del_pulse,
  input logic          full_pulse,
  input logic          full_err,
  input logic          ins_pulse,
  input logic          empty_pulse,
  input logic          empty_err
);
  // R2
  del_after_skip_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    del_pulse |-> $past(in_valid && in_skip));
  // R2
  del_full_excl_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    !(del_pulse && full_pulse));
  // R5
  full_sticky_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    full_err |=> full_err);
  // R5
  full_flag_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    full_pulse |-> full_err);
  // R3
  ins_word_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    ins_pulse |-> (out_valid && out_skip && out_data == SKIP_CODE));
  // R6
  empty_word_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty_pulse |-> (out_valid && out_skip && out_data == SKIP_CODE && empty_err));
  // R6
  empty_sticky_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty_err |=> empty_err);
  // R3
  ins_empty_excl_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !(ins_pulse && empty_pulse));
  // R8
  out_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_skip)));
endmodule

bind clk_comp_buf ccb_chk #(.DW(DW), .SKIP_CODE(SKIP_CODE)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .in_valid(in_valid), .in_skip(in_skip), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_skip(out_skip),
  .del_pulse(del_pulse), .full_pulse(full_pulse), .full_err(full_err),
  .ins_pulse(ins_pulse), .empty_pulse(empty_pulse), .empty_err(empty_err)
);

// File: tb/sim_clk_comp_buf.sv
`timescale 1ns/1fs
module sim_clk_comp_buf;
  localparam int          DW   = 16;
  localparam logic [15:0] SKIP = 16'h01BC;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic in_valid = 1'b0, in_skip = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_skip;
  logic [DW-1:0] out_data;
  logic del_pulse, full_pulse, full_err, ins_pulse, empty_pulse, empty_err;

  realtime whalf = 2.5;
  always #2.5 rclk = ~rclk;
  always #(whalf) wclk = ~wclk;

  clk_comp_buf #(.DW(DW), .SKIP_CODE(SKIP)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_skip(in_skip),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_skip(out_skip),
    .del_pulse(del_pulse), .full_pulse(full_pulse), .full_err(full_err),
    .ins_pulse(ins_pulse), .empty_pulse(empty_pulse), .empty_err(empty_err)
  );

  int total = 0, bad = 0;
  int ndel = 0, nins = 0, nfull = 0;
  int dcnt = 0;
  logic [DW-1:0] exp_q [$];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_words(input int n, input bit with_skip, input bit push);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      in_valid = 1'b1;
      if (with_skip && (i % 4 == 3)) begin
        in_skip = 1'b1;
        in_data = SKIP;
      end else begin
        in_skip = 1'b0;
        in_data = dcnt[DW-1:0];
        if (push) exp_q.push_back(dcnt[DW-1:0]);
        dcnt++;
      end
    end
    @(negedge wclk);
    in_valid = 1'b0;
    in_skip  = 1'b0;
  endtask

  task automatic rwait(input int n);
    for (int i = 0; i < n; i++) @(negedge rclk);
  endtask

  task automatic do_reset();
    @(negedge rclk);
    wrst_n = 1'b0;
    rrst_n = 1'b0;
    rwait(5);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge rclk) begin
    if (rrst_n && out_valid && out_ready) begin
      if (out_skip) begin
        chk(out_data == SKIP, "R3 skip word code", int'(out_data), int'(SKIP));
      end else if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected data word", int'(out_data), -1);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R1 data order", int'(out_data), int'(e));
      end
    end
  end

  always @(negedge wclk) begin
    if (wrst_n && del_pulse) ndel++;
    if (wrst_n && full_pulse) nfull++;
  end
  always @(negedge rclk) if (rrst_n && ins_pulse) nins++;

  // watchdog
  initial begin
    for (int i = 0; i < 190000; i++) @(posedge rclk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d0, i0;
    do_reset();
    rwait(3);
    // R7 reset state
    chk(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
    chk({del_pulse, full_pulse, full_err, ins_pulse, empty_pulse, empty_err} == 6'b0,
        "R7 status after reset", 1, 0);
    // R8 write side ready
    chk(in_ready == 1'b1, "R8 in_ready", int'(in_ready), 1);
    // R7 priming: four words do not release the output
    drive_words(4, 1'b0, 1'b1);
    rwait(20);
    chk(out_valid == 1'b0, "R7 held below half depth", int'(out_valid), 0);

    // R9 write clock 300 ppm fast
    whalf = 2.5 * (1.0 - 300.0e-6);
    drive_words(60000, 1'b1, 1'b1);
    d0 = ndel;
    chk(d0 > 0, "R9 deletions at +300ppm", d0, 1);
    // R9 write clock 300 ppm slow (continues stream)
    whalf = 2.5 * (1.0 + 300.0e-6);
    i0 = nins;
    drive_words(60000, 1'b1, 1'b1);
    chk(nins > i0, "R9 insertions at -300ppm", nins - i0, 1);
    chk(full_err == 1'b0, "R9 no full", int'(full_err), 0);
    chk(empty_err == 1'b0, "R9 no empty", int'(empty_err), 0);
    chk(nfull == 0, "R4 no data discarded", nfull, 0);

    // R6 drain data-only tail to empty
    drive_words(24, 1'b0, 1'b1);
    rwait(200);
    chk(exp_q.size() == 0, "R1 all data delivered", exp_q.size(), 0);
    chk(empty_err == 1'b1, "R6 empty sticky", int'(empty_err), 1);
    chk(out_skip == 1'b1 && out_data == SKIP, "R6 empty fill word", int'(out_data), int'(SKIP));

    // R5 overflow with stalled reader
    whalf = 2.5;
    exp_q.delete();
    out_ready = 1'b0;
    do_reset();
    rwait(2);
    chk(empty_err == 1'b0, "R6 reset clears sticky", int'(empty_err), 0);
    dcnt = 0;
    for (int k = 0; k <= 16; k++) exp_q.push_back(k[DW-1:0]);
    nfull = 0;
    drive_words(40, 1'b0, 1'b0);
    rwait(50);
    chk(full_err == 1'b1, "R5 full sticky", int'(full_err), 1);
    chk(nfull > 0, "R5 full pulses", nfull, 1);
    chk(out_valid == 1'b1 && out_data == 16'd0, "R8 output held while stalled", int'(out_data), 0);
    @(negedge rclk);
    out_ready = 1'b1;
    rwait(100);
    chk(exp_q.size() == 0, "R5 stored words delivered", exp_q.size(), 0);
    chk(full_err == 1'b1, "R5 still sticky", int'(full_err), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule